// File: doc/BRIEF.md
# Cascadable Multi-Channel Pulse Scaler Bank

The block is a bank of independent binary event counters (twelve by default, each 24 bits wide) that share a common set of controls. Every channel has its own pulse input. The input passes through a synchronizer and a rising-edge detector, so each pulse adds one count, however many clock cycles it stays high.

One inhibit line gates the pulse inputs of all channels. The inhibit goes through the same number of synchronizer stages as the pulses, so the two stay aligned, and it is held on for a few extra cycles after it drops. The inhibit only masks detected edges and never produces one, so toggling it cannot add a count. A fast-clear input zeroes the whole bank in one cycle. A test-increment strobe advances every channel by one for each cycle it is high, and it works even while the inhibit is on. Each even/odd channel pair can be joined by a configuration bit into one counter of twice the width. In that mode the odd channel counts the carries out of the even channel. Every unjoined channel raises a sticky flag once its top bit has been set. This flag is meant to feed an interrupt.

All inputs are single-bit digital signals in the clock domain of the block. The pairing configuration is treated as static while counting.

Top module: `pulse_scaler_bank`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, every channel count is 0 and half_flag and flag_any are 0.
- R2: A rising edge on pulse_in[i] adds exactly one to channel i, whatever the pulse width. The count changes on the third rising clock edge after the first edge that samples the input high.
- R3: When a detected input edge coincides with an active inhibit, the count does not change. Raising or dropping inhibit_in with no pulse edge never changes any count, including when a pulse that rose under inhibit is still high at release.
- R4: The inhibit stays effective for INH_HOLD cycles (default 4) after it drops. Let d be the number of clock edges from the first edge that samples inhibit_in low to the first edge that samples a pulse high. That pulse is rejected when d < INH_HOLD and counted when d >= INH_HOLD.
- R5: fast_clear high at a clock edge sets every count and every flag to 0 at that edge. This overrides test_inc and pulse edges in the same cycle.
- R6: Each clock edge with test_inc high advances every counting channel by exactly one, whether or not the inhibit is active.
- R7: A test_inc strobe in the same cycle as a detected pulse edge advances the channel by one, not two.
- R8: An unpaired channel at its all-ones value wraps to 0 on its next increment.
- R9: pair_cfg bit p joins channel 2p (low half, count_flat bits [2p*CW +: CW]) with channel 2p+1 (high half). The high channel increments at exactly the edges where the low channel wraps from all ones, and its own pulse input and test_inc have no direct effect on it.
- R10: half_flag[i] goes to 1 at the same edge where bit CW-1 of channel i becomes 1. It stays at 1, even after a wrap, until fast_clear or reset. flag_any is the OR of all half_flag bits.
- R11: Both channels of a joined pair keep half_flag at 0, even after the low half has passed its top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | NCH | Per-channel pulse inputs, asynchronous |
| inhibit_in | input | 1 | Common inhibit, asynchronous, high blocks pulse counting |
| fast_clear | input | 1 | Synchronous clear of all counts and flags |
| test_inc | input | 1 | Synchronous test strobe, +1 on all counting channels per cycle |
| pair_cfg | input | NCH/2 | Bit p joins channel 2p and 2p+1 into one double-width counter |
| count_flat | output | NCH*CW | Channel i count in bits [i*CW +: CW] |
| half_flag | output | NCH | Sticky per-channel top-bit flag |
| flag_any | output | 1 | OR of half_flag |

## Verification
The bench targets the edges of the inhibit hold window. It checks the last rejected offset and the first accepted offset after release; an off-by-one in the hold counter or in the sync alignment shifts one of them. It also lets an input rise under inhibit and releases the inhibit while the input is still high; a design that gated the level instead of the edge would add a spurious count there. It drives test_inc on the same cycle as an edge, where a design that added the two sources would step by two. It runs a joined pair through the wrap, where a carry taken a cycle late, or a high half that still follows its own input, shows up as a wrong high count. It checks that the flag of a joined pair stays silent and that the flag of a solo channel survives a wrap.

// File: rtl/scaler_pkg.sv
package scaler_pkg;

   // Role a channel plays, given its index and its pair's join bit.
   typedef enum logic [1:0] {
      ROLE_SOLO = 2'd0,
      ROLE_LOW  = 2'd1,
      ROLE_HIGH = 2'd2
   } lane_role_e;

   function automatic lane_role_e lane_role(input int idx, input logic joined);
      if (!joined)
         return ROLE_SOLO;
      else if ((idx % 2) == 0)
         return ROLE_LOW;
      else
         return ROLE_HIGH;
   endfunction

   // Bits needed for a down-counter holding values 0..n.
   function automatic int hold_bits(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/scaler_sync.sv
module scaler_sync #(
   parameter int STAGES = 2,
   parameter int LANES  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] d,
   output logic [LANES-1:0] q
);

   logic [LANES-1:0] pipe_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) pipe_q[k] <= '0;
      end else begin
         pipe_q[0] <= d;
         for (int k = 1; k < STAGES; k++) pipe_q[k] <= pipe_q[k-1];
      end
   end

   assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/scaler_rise.sv
module scaler_rise #(
   parameter int LANES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] level,
   output logic [LANES-1:0] rise
);

   logic [LANES-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   assign rise = level & ~prev_q;

endmodule

// File: rtl/scaler_inhibit_hold.sv
module scaler_inhibit_hold
   import scaler_pkg::*;
#(
   parameter int HOLD = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inh_sync,
   output logic inh_eff
);

   localparam int HW = hold_bits(HOLD);
   localparam logic [HW-1:0] HOLD_V = HW'(HOLD);

   logic [HW-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= '0;
      else if (inh_sync)
         hold_q <= HOLD_V;
      else if (hold_q != '0)
         hold_q <= hold_q - 1'b1;
   end

   assign inh_eff = inh_sync | (hold_q != '0);

endmodule

// File: rtl/scaler_channel.sv
module scaler_channel #(
   parameter int CW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   input  logic          flag_en,
   output logic [CW-1:0] count,
   output logic          flag
);

   logic [CW-1:0] cnt_q, cnt_d;
   logic          flag_q;

   always_comb begin
      if (clr)      cnt_d = '0;
      else if (inc) cnt_d = cnt_q + 1'b1;
      else          cnt_d = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         flag_q <= clr ? 1'b0 : (flag_q | (flag_en & cnt_d[CW-1]));
      end
   end

   assign count = cnt_q;
   assign flag  = flag_q & flag_en;

endmodule

// File: rtl/pulse_scaler_bank.sv
module pulse_scaler_bank
   import scaler_pkg::*;
#(
   parameter int NCH         = 12,
   parameter int CW          = 24,
   parameter int SYNC_STAGES = 2,
   parameter int INH_HOLD    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NCH-1:0]      pulse_in,
   input  logic                inhibit_in,
   input  logic                fast_clear,
   input  logic                test_inc,
   input  logic [NCH/2-1:0]    pair_cfg,
   output logic [NCH*CW-1:0]   count_flat,
   output logic [NCH-1:0]      half_flag,
   output logic                flag_any
);

   localparam int NPAIR = NCH / 2;
   localparam logic [CW-1:0] CNT_TOP = '1;

   if ((NCH % 2) != 0 || NCH < 2) begin : g_bad_nch
      $error("pulse_scaler_bank: NCH must be even and at least 2");
   end
   if (CW < 2) begin : g_bad_cw
      $error("pulse_scaler_bank: CW must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pulse_scaler_bank: SYNC_STAGES must be at least 2");
   end
   if (INH_HOLD < 1) begin : g_bad_hold
      $error("pulse_scaler_bank: INH_HOLD must be at least 1");
   end

   logic [NCH-1:0]   pulse_sync;
   logic [NCH-1:0]   pulse_rise;
   logic             inh_sync;
   logic             inh_eff;
   logic [NCH-1:0]   own_inc;
   logic [NCH-1:0]   inc_vec;
   logic [NCH-1:0]   flag_en;
   logic [NPAIR-1:0] low_wrap;

   // Pulse path: synchronizer then edge detector.
   scaler_sync #(.STAGES(SYNC_STAGES), .LANES(NCH)) u_pulse_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pulse_in),
      .q     (pulse_sync)
   );

   scaler_rise #(.LANES(NCH)) u_pulse_rise (
      .clk   (clk),
      .rst_n (rst_n),
      .level (pulse_sync),
      .rise  (pulse_rise)
   );

   // Inhibit path: same sync depth so it lines up with the edges.
   scaler_sync #(.STAGES(SYNC_STAGES), .LANES(1)) u_inh_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (inhibit_in),
      .q     (inh_sync)
   );

   scaler_inhibit_hold #(.HOLD(INH_HOLD)) u_inh_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .inh_sync (inh_sync),
      .inh_eff  (inh_eff)
   );

   // Gated edges merged with the test strobe: at most one step per cycle.
   assign own_inc = (pulse_rise & {NCH{~inh_eff}}) | {NCH{test_inc}};

   // Carry out of each pair's low half.
   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      assign low_wrap[p] = own_inc[2*p] & (count_flat[(2*p)*CW +: CW] == CNT_TOP);
   end

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      lane_role_e role;
      assign role = lane_role(i, pair_cfg[i/2]);

      if ((i % 2) == 1) begin : g_odd
         assign inc_vec[i] = (role == ROLE_HIGH) ? low_wrap[i/2] : own_inc[i];
      end else begin : g_even
         assign inc_vec[i] = own_inc[i];
      end

      assign flag_en[i] = (role == ROLE_SOLO);

      scaler_channel #(.CW(CW)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (fast_clear),
         .inc     (inc_vec[i]),
         .flag_en (flag_en[i]),
         .count   (count_flat[i*CW +: CW]),
         .flag    (half_flag[i])
      );
   end

   assign flag_any = |half_flag;

endmodule

// File: rtl/scaler_bank_chk.sv
module scaler_bank_chk #(
   parameter int NCH = 12,
   parameter int CW  = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fast_clear,
   input logic              test_inc,
   input logic [NCH/2-1:0]  pair_cfg,
   input logic [NCH*CW-1:0] count_flat,
   input logic [NCH-1:0]    half_flag
);

   localparam logic [CW-1:0] TOP = '1;

   // R5
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fast_clear |=> (count_flat == '0) && (half_flag == '0));

   for (genvar i = 0; i < NCH; i++) begin : g_lane
      // R2 R7
      single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !fast_clear |=> (count_flat[i*CW +: CW] == $past(count_flat[i*CW +: CW])) ||
                         (count_flat[i*CW +: CW] == $past(count_flat[i*CW +: CW]) + 1'b1));

      // R10
      flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         half_flag[i] && !fast_clear |=> half_flag[i] || pair_cfg[i/2]);

      if ((i % 2) == 0) begin : g_even
         // R6
         test_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            test_inc && !fast_clear |=>
               count_flat[i*CW +: CW] == $past(count_flat[i*CW +: CW]) + 1'b1);
      end else begin : g_odd
         // R6
         test_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            test_inc && !fast_clear && !pair_cfg[i/2] |=>
               count_flat[i*CW +: CW] == $past(count_flat[i*CW +: CW]) + 1'b1);
      end
   end

   for (genvar p = 0; p < NCH/2; p++) begin : g_pairchk
      // R9
      pair_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pair_cfg[p] && test_inc && !fast_clear && (count_flat[(2*p)*CW +: CW] == TOP) |=>
            (count_flat[(2*p)*CW +: CW] == '0) &&
            (count_flat[(2*p+1)*CW +: CW] == $past(count_flat[(2*p+1)*CW +: CW]) + 1'b1));

      // R9
      pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pair_cfg[p] && !fast_clear && (count_flat[(2*p)*CW +: CW] != TOP) |=>
            count_flat[(2*p+1)*CW +: CW] == $past(count_flat[(2*p+1)*CW +: CW]));

      // R11
      pair_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pair_cfg[p] |-> !half_flag[2*p] && !half_flag[2*p+1]);
   end

endmodule

bind pulse_scaler_bank scaler_bank_chk #(.NCH(NCH), .CW(CW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fast_clear (fast_clear),
   .test_inc   (test_inc),
   .pair_cfg   (pair_cfg),
   .count_flat (count_flat),
   .half_flag  (half_flag)
);

// File: tb/sim_pulse_scaler_bank.sv
`timescale 1ns/100ps
module sim_pulse_scaler_bank;

   localparam int NCH  = 12;
   localparam int CW   = 6;
   localparam int HOLD = 4;
   localparam int MOD  = 1 << CW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NCH-1:0]    pulse_in = '0;
   logic              inhibit_in = 1'b0;
   logic              fast_clear = 1'b0;
   logic              test_inc = 1'b0;
   logic [NCH/2-1:0]  pair_cfg = '0;
   logic [NCH*CW-1:0] count_flat;
   logic [NCH-1:0]    half_flag;
   logic              flag_any;

   int checks = 0;
   int failures = 0;
   int exp_cnt [NCH];

   always #2.5 clk = ~clk;

   pulse_scaler_bank #(.NCH(NCH), .CW(CW), .SYNC_STAGES(2), .INH_HOLD(HOLD)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .pulse_in   (pulse_in),
      .inhibit_in (inhibit_in),
      .fast_clear (fast_clear),
      .test_inc   (test_inc),
      .pair_cfg   (pair_cfg),
      .count_flat (count_flat),
      .half_flag  (half_flag),
      .flag_any   (flag_any)
   );

   // Stimulus table: pulse mask, inhibit, test strobe, channels expected to step.
   localparam logic [25:0] VEC_TAB [6] = '{
      {12'h001, 1'b0, 1'b0, 12'h001},
      {12'hFFF, 1'b0, 1'b0, 12'hFFF},
      {12'hAAA, 1'b1, 1'b0, 12'h000},
      {12'h000, 1'b0, 1'b1, 12'hFFF},
      {12'h555, 1'b0, 1'b1, 12'hFFF},
      {12'h0F0, 1'b1, 1'b1, 12'hFFF}
   };

   function automatic int cnt_of(input int ch);
      return int'(count_flat[ch*CW +: CW]);
   endfunction

   task automatic check_counts(input string req);
      bit bad = 0;
      checks++;
      for (int ch = 0; ch < NCH; ch++) begin
         if (cnt_of(ch) != exp_cnt[ch]) begin
            $display("FAIL %s ch%0d count actual=%0d expected=%0d", req, ch, cnt_of(ch), exp_cnt[ch]);
            bad = 1;
         end
      end
      if (bad) failures++;
   endtask

   task automatic check_flags(input logic [NCH-1:0] exp_f, input string req);
      checks++;
      if (half_flag !== exp_f || flag_any !== (|exp_f)) begin
         failures++;
         $display("FAIL %s flags actual=%h/%b expected=%h/%b", req, half_flag, flag_any, exp_f, |exp_f);
      end
   endtask

   task automatic send_pulse(input logic [NCH-1:0] m, input logic inh, input logic t);
      @(negedge clk); pulse_in = m; inhibit_in = inh;
      @(negedge clk);
      @(negedge clk); test_inc = t;
      @(negedge clk); test_inc = 1'b0;
      repeat (3) @(negedge clk);
      pulse_in = '0;
      repeat (3) @(negedge clk);
      inhibit_in = 1'b0;
      repeat (HOLD + 6) @(negedge clk);
   endtask

   task automatic burst(input int n);
      @(negedge clk); test_inc = 1'b1;
      repeat (n) @(negedge clk);
      test_inc = 1'b0;
   endtask

   task automatic do_clear(input logic t);
      @(negedge clk); fast_clear = 1'b1; test_inc = t;
      @(negedge clk); fast_clear = 1'b0; test_inc = 1'b0;
      for (int ch = 0; ch < NCH; ch++) exp_cnt[ch] = 0;
   endtask

   task automatic release_test(input int d);
      @(negedge clk); inhibit_in = 1'b1;
      repeat (6) @(negedge clk);
      inhibit_in = 1'b0;
      repeat (d) @(negedge clk);
      pulse_in = '1;
      repeat (4) @(negedge clk);
      pulse_in = '0;
      repeat (HOLD + 8) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int ch = 0; ch < NCH; ch++) exp_cnt[ch] = 0;
      repeat (3) @(negedge clk);
      // R1: reset state while held and right after release
      check_counts("R1");
      check_flags('0, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_counts("R1");

      // Table walk: R2 R3 R6 R7
      for (int v = 0; v < 6; v++) begin
         logic [25:0] e;
         e = VEC_TAB[v];
         send_pulse(e[25:14], e[13], e[12]);
         for (int ch = 0; ch < NCH; ch++)
            if (e[ch]) exp_cnt[ch] = (exp_cnt[ch] + 1) % MOD;
         check_counts($sformatf("R2/R3/R6/R7 vec%0d", v));
      end
      check_flags('0, "R10 below top bit");

      // R2: latency of exactly three edges, wide pulse counts once
      @(negedge clk); pulse_in = 12'h020;
      @(negedge clk); check_counts("R2 latency edge1");
      @(negedge clk); check_counts("R2 latency edge2");
      @(negedge clk); exp_cnt[5]++; check_counts("R2 latency edge3");
      repeat (6) @(negedge clk);
      pulse_in = '0;
      repeat (4) @(negedge clk);
      check_counts("R2 wide pulse once");

      // R3: inhibit toggling alone never counts
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk); inhibit_in = 1'b1;
         repeat (k) @(negedge clk);
         inhibit_in = 1'b0;
         repeat (k + 1) @(negedge clk);
      end
      repeat (HOLD + 4) @(negedge clk);
      check_counts("R3 toggle only");
      // R3: pulse rises under inhibit, stays high through release
      @(negedge clk); inhibit_in = 1'b1;
      repeat (3) @(negedge clk);
      pulse_in = '1;
      repeat (4) @(negedge clk);
      inhibit_in = 1'b0;
      repeat (HOLD + 6) @(negedge clk);
      pulse_in = '0;
      repeat (4) @(negedge clk);
      check_counts("R3 release under high pulse");

      // R4: hold window boundary
      release_test(HOLD - 2);
      check_counts("R4 inside hold rejected");
      release_test(HOLD - 1);
      check_counts("R4 last rejected offset");
      release_test(HOLD);
      for (int ch = 0; ch < NCH; ch++) exp_cnt[ch]++;
      check_counts("R4 first accepted offset");

      // R10 / R8: top bit flag and wrap on solo channels
      do_clear(1'b0);
      check_counts("R5 clear");
      burst(MOD / 2 - 1);
      for (int ch = 0; ch < NCH; ch++) exp_cnt[ch] = MOD / 2 - 1;
      check_counts("R6 burst");
      check_flags('0, "R10 just below top bit");
      burst(1);
      for (int ch = 0; ch < NCH; ch++) exp_cnt[ch] = MOD / 2;
      check_counts("R6 single strobe");
      check_flags('1, "R10 top bit set");
      burst(MOD / 2);
      for (int ch = 0; ch < NCH; ch++) exp_cnt[ch] = 0;
      check_counts("R8 wrap to zero");
      check_flags('1, "R10 sticky across wrap");

      // R5: clear beats a coincident test strobe
      burst(3);
      do_clear(1'b1);
      check_counts("R5 clear with strobe");
      check_flags('0, "R5 flags cleared");

      // R9 / R11: join pairs 0-1 and 2-3
      @(negedge clk); pair_cfg = 6'b000011;
      burst(MOD - 1);
      for (int ch = 0; ch < NCH; ch++) exp_cnt[ch] = (ch == 1 || ch == 3) ? 0 : MOD - 1;
      check_counts("R9 low half full, high idle");
      check_flags(12'hFF0, "R11 joined pairs quiet");
      burst(1);
      for (int ch = 0; ch < NCH; ch++) exp_cnt[ch] = (ch == 1 || ch == 3) ? 1 : 0;
      check_counts("R9 carry into high half");
      send_pulse(12'h00A, 1'b0, 1'b0);
      check_counts("R9 high half ignores own input");
      send_pulse(12'h001, 1'b0, 1'b0);
      exp_cnt[0] = 1;
      check_counts("R9 low half counts pulse");
      check_flags(12'hFF0, "R11 flags after carry");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule